// File: doc/BRIEF.md
# Playback Ring-Buffer DMA Engine

This block feeds an audio output path from a circular buffer in system memory. It fetches fixed 8-byte bursts over a 64-bit request/grant memory port and stores them in an internal byte FIFO. A downstream serializer drains the FIFO one byte at a time. A fetch is requested whenever the FIFO has fallen to a programmable level and still has room for a whole burst. After the burst at the last buffer address, the memory pointer wraps to the buffer base.

Software drives the block through a 32-bit register port. Registers sit on a 4-byte stride and are written in one cycle; reads are combinational. The registers hold:

- the buffer base address, the address of the last burst, and an initial pointer;
- an interrupt period counted in bursts;
- a FIFO request threshold, encoded as bursts minus one;
- interrupt enables and level-style interrupt clears;
- a selector for what the second status register reports.

Two interrupt sources exist: a period source that re-arms itself every N bursts, and a buffer-wrap source. Both are OR-ed, after masking, onto one interrupt line.

The FIFO depth is a parameter. It must be a power of two and at least 256 bytes.

Top module: `afd_play_dma`

## Requirements
- R1: After reset, every register reads 0, and irq, mem_req and aud_valid are low.
- R2: The base (0x08), last (0x0C) and initial (0x10) address registers keep bits 31:3 and read bits 2:0 as 0. While the enable (CTRL0 at 0x00, bit 0) is 0, the pointer reloads from the initial register on every cycle.
- R3: A burst is accepted when mem_req and mem_gnt are high together, and it reads mem_addr (the pointer). The pointer then advances by 8, except that a burst accepted at the last address sends the pointer to the base, not to the initial address.
- R4: mem_req is high exactly when all three hold: enable is 1, the FIFO fill is at most (THRESH[7:0]+1)*8 bytes (THRESH at 0x18), and the fill is at most DEPTH-8.
- R5: PERIOD (0x14, bits 15:0) holds N. Status bit 0 (STAT1 at 0x1C) sets on the accepted burst that completes each Nth burst since enable. With N=0 it never sets.
- R6: Status bit 1 (STAT1 at 0x1C) sets on a burst accepted at the last address.
- R7: Clear bits live in CTRL1 (0x04), bits 1:0. While a clear bit is 1, the matching status bit reads 0 and cannot set. Once software writes the bit back to 0, the next event sets the status bit again.
- R8: irq is the OR over sources of status AND enable, with the enables in CTRL0 bits 9:8.
- R9: aud_valid is high whenever the fill is nonzero. aud_byte is the oldest byte. A burst is unpacked low byte first (beat bits 7:0 come out first). A pop while empty changes nothing.
- R10: Clearing the enable stops requests and keeps every programmed register. The burst count reads 0 while disabled, so the period count starts over on the next enable.
- R11: STAT2 (0x20) returns, according to CTRL1 bits 5:4: 0 gives the pointer, 1 gives the fill in bytes, 2 gives the burst count, 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address, shared by reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Burst fetch request |
| mem_addr | output | 32 | Burst address (current pointer) |
| mem_gnt | input | 1 | Grant; completes the burst in the same cycle |
| mem_rdata | input | 64 | Burst data, valid with the grant |
| aud_pop | input | 1 | Take one byte from the FIFO |
| aud_byte | output | 8 | Oldest FIFO byte |
| aud_valid | output | 1 | FIFO not empty |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench goes after the wrap target by using an initial pointer in the middle of the buffer. A design that wrapped to the initial address, or ran one burst past the last address, would put a wrong mem_addr on the port. It holds a clear bit high across later period and wrap events; a design that treated the clear as a pulse would show the status bit set again while the clear was still held. It toggles the enable and covers period zero, threshold codes 0 and above the FIFO depth, and pops on an empty FIFO. These cases catch an off-by-one in the threshold decode, a burst counter that survives a disable, and a fill count that goes negative.

// File: rtl/afd_pkg.sv
package afd_pkg;
    localparam int ADDR_W      = 32;
    localparam int BEAT_W      = 64;
    localparam int BURST_BYTES = BEAT_W / 8;
    localparam int BURST_SHIFT = $clog2(BURST_BYTES);
    localparam int NUM_SRC     = 2;
    localparam int PERIOD_W    = 16;
    localparam int THR_W       = 8;
    localparam int THRB_W      = THR_W + BURST_SHIFT + 1;

    // interrupt source indices
    localparam int SRC_PERIOD = 0;
    localparam int SRC_WRAP   = 1;

    // register byte offsets
    localparam int OFS_CTRL0  = 'h00;
    localparam int OFS_CTRL1  = 'h04;
    localparam int OFS_BASE   = 'h08;
    localparam int OFS_LAST   = 'h0C;
    localparam int OFS_INIT   = 'h10;
    localparam int OFS_PERIOD = 'h14;
    localparam int OFS_THRESH = 'h18;
    localparam int OFS_STAT1  = 'h1C;
    localparam int OFS_STAT2  = 'h20;

    // field positions
    localparam int CTRL0_EN_BIT  = 0;
    localparam int CTRL0_IEN_LSB = 8;
    localparam int CTRL1_CLR_LSB = 0;
    localparam int CTRL1_SEL_LSB = 4;

    typedef enum logic [1:0] {
        ST2_PTR  = 2'd0,
        ST2_FILL = 2'd1,
        ST2_BCNT = 2'd2,
        ST2_NONE = 2'd3
    } st2_sel_e;

    typedef struct packed {
        logic                dma_en;
        logic [NUM_SRC-1:0]  irq_en;
        logic [NUM_SRC-1:0]  irq_clr;
        st2_sel_e            st2_sel;
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   last;
        logic [ADDR_W-1:0]   init;
        logic [PERIOD_W-1:0] period;
        logic [THR_W-1:0]    thr;
    } cfg_t;

    // drop the byte-within-burst bits of an address
    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:BURST_SHIFT], {BURST_SHIFT{1'b0}}};
    endfunction

    // threshold code (bursts minus one) to a byte level
    function automatic logic [THRB_W-1:0] thr_to_bytes(input logic [THR_W-1:0] code);
        logic [THRB_W-1:0] bursts;
        bursts = {{BURST_SHIFT{1'b0}}, ({1'b0, code} + 1'b1)};
        return bursts << BURST_SHIFT;
    endfunction
endpackage

// File: rtl/afd_regs.sv
module afd_regs
    import afd_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int FILL_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [31:0]         wdata,
    input  logic [NUM_SRC-1:0]  pend,
    input  logic [ADDR_W-1:0]   ptr,
    input  logic [FILL_W-1:0]   fill,
    input  logic [PERIOD_W-1:0] bcnt,
    output cfg_t                cfg,
    output logic [31:0]         rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_AW'(OFS_CTRL0): begin
                    cfg.dma_en <= wdata[CTRL0_EN_BIT];
                    cfg.irq_en <= wdata[CTRL0_IEN_LSB +: NUM_SRC];
                end
                REG_AW'(OFS_CTRL1): begin
                    cfg.irq_clr <= wdata[CTRL1_CLR_LSB +: NUM_SRC];
                    cfg.st2_sel <= st2_sel_e'(wdata[CTRL1_SEL_LSB +: 2]);
                end
                REG_AW'(OFS_BASE):   cfg.base   <= align_addr(wdata);
                REG_AW'(OFS_LAST):   cfg.last   <= align_addr(wdata);
                REG_AW'(OFS_INIT):   cfg.init   <= align_addr(wdata);
                REG_AW'(OFS_PERIOD): cfg.period <= wdata[PERIOD_W-1:0];
                REG_AW'(OFS_THRESH): cfg.thr    <= wdata[THR_W-1:0];
                default: ;
            endcase
        end
    end

    logic [31:0] stat2;

    always_comb begin
        case (cfg.st2_sel)
            ST2_PTR:  stat2 = ptr;
            ST2_FILL: stat2 = 32'(fill);
            ST2_BCNT: stat2 = 32'(bcnt);
            default:  stat2 = '0;
        endcase
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_AW'(OFS_CTRL0): begin
                rdata[CTRL0_EN_BIT]               = cfg.dma_en;
                rdata[CTRL0_IEN_LSB +: NUM_SRC]   = cfg.irq_en;
            end
            REG_AW'(OFS_CTRL1): begin
                rdata[CTRL1_CLR_LSB +: NUM_SRC]   = cfg.irq_clr;
                rdata[CTRL1_SEL_LSB +: 2]         = cfg.st2_sel;
            end
            REG_AW'(OFS_BASE):   rdata = cfg.base;
            REG_AW'(OFS_LAST):   rdata = cfg.last;
            REG_AW'(OFS_INIT):   rdata = cfg.init;
            REG_AW'(OFS_PERIOD): rdata = 32'(cfg.period);
            REG_AW'(OFS_THRESH): rdata = 32'(cfg.thr);
            REG_AW'(OFS_STAT1):  rdata = 32'(pend);
            REG_AW'(OFS_STAT2):  rdata = stat2;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/afd_ptr.sv
module afd_ptr
    import afd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dma_en,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   last,
    input  logic [ADDR_W-1:0]   init,
    input  logic [PERIOD_W-1:0] period,
    input  logic                grant,
    output logic [ADDR_W-1:0]   ptr,
    output logic [PERIOD_W-1:0] bcnt,
    output logic [NUM_SRC-1:0]  ev
);
    logic [PERIOD_W-1:0] bcnt_inc;
    logic                period_hit;
    logic                at_last;

    assign bcnt_inc   = bcnt + 1'b1;
    assign period_hit = (period != '0) && (bcnt_inc == period);
    assign at_last    = (ptr == last);

    always_comb begin
        ev             = '0;
        ev[SRC_PERIOD] = grant && period_hit;
        ev[SRC_WRAP]   = grant && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            bcnt <= '0;
        end else if (!dma_en) begin
            ptr  <= init;
            bcnt <= '0;
        end else if (grant) begin
            ptr  <= at_last ? base : ptr + ADDR_W'(BURST_BYTES);
            bcnt <= period_hit ? '0 : bcnt_inc;
        end
    end
endmodule

// File: rtl/afd_irq.sv
module afd_irq
    import afd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ev,
    input  logic [NUM_SRC-1:0] clr,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] pend,
    output logic               irq
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst)          pend_q <= 1'b0;
            else if (clr[i])  pend_q <= 1'b0;
            else if (ev[i])   pend_q <= 1'b1;
        end
        assign pend[i] = pend_q;
    end

    assign irq = |(pend & en);
endmodule

// File: rtl/afd_fifo.sv
module afd_fifo
    import afd_pkg::*;
#(
    parameter  int DEPTH  = 256,
    localparam int WORDS  = DEPTH / BURST_BYTES,
    localparam int W_AW   = $clog2(WORDS),
    localparam int R_AW   = $clog2(DEPTH),
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BEAT_W-1:0] push_beat,
    input  logic              pop,
    output logic [7:0]        out_byte,
    output logic              valid,
    output logic [FILL_W-1:0] fill
);
    logic [BEAT_W-1:0] mem [WORDS];
    logic [W_AW-1:0]   wptr;
    logic [R_AW-1:0]   rptr;
    logic              acc_push;
    logic              acc_pop;
    logic [BEAT_W-1:0] head;

    assign acc_push = push && (fill <= FILL_W'(DEPTH - BURST_BYTES));
    assign acc_pop  = pop && (fill != '0);
    assign valid    = (fill != '0);
    assign head     = mem[rptr[R_AW-1:BURST_SHIFT]];
    assign out_byte = head[{rptr[BURST_SHIFT-1:0], 3'b000} +: 8];

    always_ff @(posedge clk) begin
        if (acc_push) mem[wptr] <= push_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (acc_push) wptr <= wptr + 1'b1;
            if (acc_pop)  rptr <= rptr + 1'b1;
            fill <= fill + (acc_push ? FILL_W'(BURST_BYTES) : '0)
                         - (acc_pop  ? FILL_W'(1) : '0);
        end
    end
endmodule

// File: rtl/afd_play_dma.sv
module afd_play_dma
    import afd_pkg::*;
#(
    parameter  int DEPTH  = 256,
    parameter  int REG_AW = 8,
    localparam int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic [BEAT_W-1:0] mem_rdata,
    input  logic              aud_pop,
    output logic [7:0]        aud_byte,
    output logic              aud_valid,
    output logic              irq
);
    cfg_t                cfg;
    logic [ADDR_W-1:0]   ptr;
    logic [PERIOD_W-1:0] bcnt;
    logic [NUM_SRC-1:0]  ev;
    logic [NUM_SRC-1:0]  pend;
    logic [FILL_W-1:0]   fill;
    logic [THRB_W-1:0]   thr_bytes;
    logic                room_ok;
    logic                level_ok;
    logic                grant;

    // named views for the bound checker
    logic                dma_on;
    logic [ADDR_W-1:0]   base_w;
    logic [ADDR_W-1:0]   init_w;
    logic [NUM_SRC-1:0]  irq_en_w;

    assign dma_on   = cfg.dma_en;
    assign base_w   = cfg.base;
    assign init_w   = cfg.init;
    assign irq_en_w = cfg.irq_en;

    assign thr_bytes = thr_to_bytes(cfg.thr);
    assign room_ok   = fill <= FILL_W'(DEPTH - BURST_BYTES);
    assign level_ok  = 32'(fill) <= 32'(thr_bytes);
    assign mem_req   = dma_on && room_ok && level_ok;
    assign grant     = mem_req && mem_gnt;
    assign mem_addr  = ptr;

    afd_regs #(.REG_AW(REG_AW), .FILL_W(FILL_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .pend  (pend),
        .ptr   (ptr),
        .fill  (fill),
        .bcnt  (bcnt),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    afd_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .dma_en (cfg.dma_en),
        .base   (cfg.base),
        .last   (cfg.last),
        .init   (cfg.init),
        .period (cfg.period),
        .grant  (grant),
        .ptr    (ptr),
        .bcnt   (bcnt),
        .ev     (ev)
    );

    afd_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .clr  (cfg.irq_clr),
        .en   (cfg.irq_en),
        .pend (pend),
        .irq  (irq)
    );

    afd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (grant),
        .push_beat (mem_rdata),
        .pop       (aud_pop),
        .out_byte  (aud_byte),
        .valid     (aud_valid),
        .fill      (fill)
    );
endmodule

// File: rtl/afd_play_dma_chk.sv
module afd_play_dma_chk
    import afd_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int FILL_W = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               dma_on,
    input logic               mem_req,
    input logic               mem_gnt,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [ADDR_W-1:0]  base_w,
    input logic [ADDR_W-1:0]  init_w,
    input logic [FILL_W-1:0]  fill,
    input logic               aud_pop,
    input logic               irq,
    input logic [NUM_SRC-1:0] irq_en_w
);
    p_req_en_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> dma_on);

    p_req_room_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (32'(fill) <= DEPTH - BURST_BYTES));

    p_addr_align_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[BURST_SHIFT-1:0] == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=>
            ((mem_addr == $past(mem_addr) + ADDR_W'(BURST_BYTES)) || (mem_addr == $past(base_w))));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (dma_on && !(mem_req && mem_gnt)) |=> $stable(mem_addr));

    p_reload_r2: assert property (@(posedge clk) disable iff (rst)
        !dma_on |=> (mem_addr == $past(init_w)));

    p_fill_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!(mem_req && mem_gnt) && (!aud_pop || fill == '0)) |=> $stable(fill));

    p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
        32'(fill) <= DEPTH);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_en_w == '0) |-> !irq);
endmodule

bind afd_play_dma afd_play_dma_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dma_on   (dma_on),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .base_w   (base_w),
    .init_w   (init_w),
    .fill     (fill),
    .aud_pop  (aud_pop),
    .irq      (irq),
    .irq_en_w (irq_en_w)
);

// File: tb/tb_afd_play_dma.sv
module tb_afd_play_dma;
    import afd_pkg::*;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt;
    logic [63:0] mem_rdata;
    logic        aud_pop;
    logic [7:0]  aud_byte;
    logic        aud_valid;
    logic        irq;

    always #5 clk = ~clk;

    function automatic logic [63:0] beat_for(input logic [31:0] a);
        return {a ^ 32'h1357_9BDF, a + 32'h0246_8ACE};
    endfunction

    assign mem_rdata = beat_for(mem_addr);

    afd_play_dma #(.DEPTH(DEPTH), .REG_AW(8)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .aud_pop(aud_pop), .aud_byte(aud_byte), .aud_valid(aud_valid), .irq(irq)
    );

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    // expected state, derived from the requirements
    bit          m_en;
    logic [1:0]  m_ien, m_clr, m_pend, m_sel;
    logic [31:0] m_base, m_last, m_init, m_ptr;
    int          m_period, m_cnt, m_thr;
    logic [7:0]  q[$];

    function automatic void chk(input bit ok, input string tag,
                                input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endfunction

    function automatic bit exp_req();
        return m_en && (q.size() <= (m_thr + 1) * 8) && (q.size() <= DEPTH - 8);
    endfunction

    function automatic logic [31:0] exp_stat2();
        case (m_sel)
            2'd0: return m_ptr;
            2'd1: return q.size();
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // one clock: check outputs, drive inputs, advance expected state
    task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input bit gnt, input bit pop);
        bit er, g, p, ev0, ev1;
        logic [63:0] bt;
        int nc;
        er = exp_req();
        chk(mem_req === er, "R4 mem_req", mem_req, er);
        chk(mem_addr === m_ptr, "R3 mem_addr", mem_addr, m_ptr);
        chk(aud_valid === (q.size() != 0), "R9 aud_valid", aud_valid, q.size() != 0);
        if (q.size() != 0) chk(aud_byte === q[0], "R9 aud_byte", aud_byte, q[0]);
        chk(irq === |(m_pend & m_ien), "R8 irq", irq, |(m_pend & m_ien));
        reg_wr = wr; reg_addr = a; reg_wdata = d; mem_gnt = gnt; aud_pop = pop;
        g  = gnt && er;
        p  = pop && (q.size() != 0);
        nc = (m_cnt + 1) & 32'hFFFF;
        ev0 = g && (m_period != 0) && (nc == m_period);
        ev1 = g && (m_ptr == m_last);
        m_pend = (m_pend | {ev1, ev0}) & ~m_clr;
        if (p) void'(q.pop_front());
        if (g) begin
            bt = beat_for(m_ptr);
            for (int k = 0; k < 8; k++) q.push_back(bt[8*k +: 8]);
        end
        if (!m_en) begin
            m_ptr = m_init;
            m_cnt = 0;
        end else if (g) begin
            m_cnt = ev0 ? 0 : nc;
            m_ptr = ev1 ? m_base : m_ptr + 8;
        end
        if (wr) begin
            case (a)
                8'h00: begin m_en = d[0]; m_ien = d[9:8]; end
                8'h04: begin m_clr = d[1:0]; m_sel = d[5:4]; end
                8'h08: m_base = d & ~32'h7;
                8'h0C: m_last = d & ~32'h7;
                8'h10: m_init = d & ~32'h7;
                8'h14: m_period = d[15:0];
                8'h18: m_thr = d[7:0];
                default: ;
            endcase
        end
        @(negedge clk);
        reg_wr = 1'b0; mem_gnt = 1'b0; aud_pop = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic run(input int n, input bit gnt, input bit pop);
        repeat (n) cyc(1'b0, 8'h00, 32'h0, gnt, pop);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mem_gnt = 0; aud_pop = 0;
        m_en = 0; m_ien = 0; m_clr = 0; m_pend = 0; m_sel = 0;
        m_base = 0; m_last = 0; m_init = 0; m_ptr = 0;
        m_period = 0; m_cnt = 0; m_thr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(irq === 1'b0, "R1 irq", irq, 0);
        chk(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
        chk(aud_valid === 1'b0, "R1 aud_valid", aud_valid, 0);
        rd_chk(8'h00, 32'h0, "R1 ctrl0");
        rd_chk(8'h1C, 32'h0, "R1 stat1");
        rd_chk(8'h18, 32'h0, "R1 thresh");

        // R2: program buffer with low address bits set
        wr(8'h08, 32'h0000_1007);
        wr(8'h0C, 32'h0000_101B);
        wr(8'h10, 32'h0000_1010);
        wr(8'h14, 32'd3);
        wr(8'h18, 32'd3);
        idle(2);
        rd_chk(8'h08, 32'h0000_1000, "R2 base low bits");
        rd_chk(8'h0C, 32'h0000_1018, "R2 last low bits");
        rd_chk(8'h20, 32'h0000_1010, "R2 pointer at initial while off");

        // R3 R5 R6: enable, fetch until threshold (32 bytes) is passed
        wr(8'h00, 32'h0000_0301);
        run(6, 1'b1, 1'b0);
        wr(8'h04, 32'h0000_0010);
        rd_chk(8'h20, 32'd40, "R11 fill after five bursts");
        rd_chk(8'h1C, 32'h3, "R5 R6 period and wrap status");
        chk(mem_req === 1'b0, "R4 no request above threshold", mem_req, 0);

        // R7: clear held high across new events
        wr(8'h04, 32'h0000_0013);
        run(60, 1'b1, 1'b1);
        rd_chk(8'h1C, 32'h0, "R7 status held clear");
        wr(8'h04, 32'h0000_0010);
        run(40, 1'b1, 1'b1);
        rd_chk(8'h1C, {30'h0, m_pend}, "R7 status sets after release");
        rd_chk(8'h1C, 32'h3, "R7 both sources set again");

        // R10: disable keeps config, reloads pointer, zeroes burst count
        wr(8'h00, 32'h0000_0300);
        idle(2);
        rd_chk(8'h08, 32'h0000_1000, "R10 base kept");
        rd_chk(8'h0C, 32'h0000_1018, "R10 last kept");
        rd_chk(8'h14, 32'd3, "R10 period kept");
        wr(8'h04, 32'h0000_0020);
        rd_chk(8'h20, 32'h0, "R10 burst count zero while off");
        wr(8'h04, 32'h0000_0000);
        rd_chk(8'h20, 32'h0000_1010, "R10 pointer reloaded");

        // R9: drain and pop on empty
        run(80, 1'b0, 1'b1);
        wr(8'h04, 32'h0000_0010);
        rd_chk(8'h20, 32'h0, "R9 pop on empty ignored");

        // R5: period zero never fires
        wr(8'h14, 32'd0);
        wr(8'h04, 32'h0000_0013);
        wr(8'h04, 32'h0000_0010);
        wr(8'h00, 32'h0000_0101);
        run(120, 1'b1, 1'b1);
        reg_addr = 8'h1C; #1;
        chk(reg_rdata[0] === 1'b0, "R5 period zero", reg_rdata[0], 0);

        // random mix; threshold code 0 and codes above depth included
        wr(8'h18, 32'd0);
        run(30, 1'b1, 1'b1);
        wr(8'h18, 32'd40);
        wr(8'h14, 32'd2);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) begin
                int w;
                w = $urandom_range(0, 3);
                case (w)
                    0: wr(8'h18, $urandom_range(0, 40));
                    1: wr(8'h14, $urandom_range(0, 6));
                    2: wr(8'h00, {22'h0, 2'($urandom), 7'h0, 1'($urandom_range(0, 3) != 0)});
                    default: wr(8'h04, {26'h0, 2'($urandom), 2'b00, 1'b0, 1'($urandom_range(0, 3) == 0)});
                endcase
            end else begin
                cyc(1'b0, 8'h00, 32'h0, 1'($urandom), 1'($urandom_range(0, 2) != 0));
            end
            if (i % 50 == 49) begin
                rd_chk(8'h1C, {30'h0, m_pend}, "R5 R6 R7 status");
                rd_chk(8'h20, exp_stat2(), "R11 stat2 select");
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule